// File: doc/BRIEF.md
# Multiplexed-Bus Program Fetch Sequencer

This block runs the external instruction-fetch cycle of a small 8-bit controller core on a bus where the low address byte and the instruction byte share one bidirectional byte port. A fetch request carries a 12-bit program address. The block places the upper address bits on a dedicated high-address port for the whole cycle. It drives the low byte on the shared port, pulses an address-latch strobe so external logic can capture that byte, and then releases the port. It then pulls an active-low program-store enable so the memory can drive the instruction byte onto the port. The byte is captured on the edge where the enable returns high and is handed back with a one-period done strobe.

Every edge is placed on a whole number of oscillator periods, and one clock period equals one oscillator period. From an idle bus a fetch takes six periods. A requester that keeps its request high gets back-to-back fetches: the next latch pulse starts in the same period that the done strobe of the previous fetch is shown. The shared port is modelled as separate output-data, output-enable and input-data signals.

Top module: `mux_fetch_seq`

## Requirements
- R1: When a request is accepted at a clock edge, `ale` goes high at that edge and stays high for exactly 2 periods.
- R2: `p0_oe` is low in the first `ale`-high period. It is high in the second `ale`-high period and in the single period after `ale` falls. It is low in every other period of the fetch.
- R3: `psen_n` falls 1 period after `ale` falls and stays low for exactly 3 periods.
- R4: Whenever `psen_n` is low, `p0_oe` is low.
- R5: `p2_out` equals address bits 11..8 from the edge where a request is accepted, and it holds that value until the next request is accepted.
- R6: On the edge where `psen_n` rises, `instr_out` takes the value that `p0_in` had during the last `psen_n`-low period, and `fetch_done` goes high for exactly one period. `instr_out` keeps that value afterwards.
- R7: `fetch_req` is sampled only when the sequencer is idle or in the last `psen_n`-low period. A request seen at any other edge is ignored, so neither `ale` nor any address output changes. A request held through the last strobe period is accepted on the edge where `fetch_done` rises, which gives a fetch period of 6.
- R8: While `rst` is high, at every clock edge `ale`=0, `psen_n`=1, `p0_oe`=0, `fetch_done`=0, `instr_out`=0 and `p2_out`=0. After reset the sequencer is idle.
- R9: Whenever `p0_oe` is high, `p0_out` equals address bits 7..0 of the fetch in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | input | 1 | Fetch request, level sampled |
| fetch_addr | input | 12 | Program address of the requested fetch |
| p0_in | input | 8 | Shared port, input side |
| p0_out | output | 8 | Shared port, output side (low address byte) |
| p0_oe | output | 1 | Shared port output enable |
| p2_out | output | 4 | Dedicated high-address port |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Program-store enable, active low |
| instr_out | output | 8 | Captured instruction byte |
| fetch_done | output | 1 | One-period completion strobe |

## Verification
Counted from the edge that accepts a request, `ale` is due at once, `p0_oe` one edge later, the falling `psen_n` three edges later, and `fetch_done` with the captured byte six edges later. The bench keeps a behavioural model that advances a period counter on each rising edge using the request it sampled there. It compares every output at the following falling edge, so each result is checked in the exact period it is due. Because `p0_in` changes every period, a capture one period early or late shows up as a wrong byte. Requests that are held, pulsed mid-fetch or cut off by reset check that acceptance happens only at the allowed edges.

// File: rtl/mux_fetch_pkg.sv
package mux_fetch_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ALE  = 2'd1,
    PH_HOLD = 2'd2,
    PH_STRB = 2'd3
  } fetch_phase_t;

endpackage

// File: rtl/fetch_seq_ctrl.sv
module fetch_seq_ctrl
  import mux_fetch_pkg::*;
#(
  parameter int ALE_CYC  = 2,
  parameter int PSEN_CYC = 3,
  parameter int CNT_W    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  output logic             accept,
  output logic             strb_end,
  output fetch_phase_t     ph_nxt,
  output logic [CNT_W-1:0] cnt_nxt
);

  localparam logic [CNT_W-1:0] ALE_LAST  = CNT_W'(ALE_CYC - 1);
  localparam logic [CNT_W-1:0] PSEN_LAST = CNT_W'(PSEN_CYC - 1);

  fetch_phase_t     ph_q;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    strb_end = (ph_q == PH_STRB) && (cnt_q == PSEN_LAST);
    accept   = req && ((ph_q == PH_IDLE) || strb_end);
  end

  always_comb begin
    ph_nxt  = ph_q;
    cnt_nxt = cnt_q;
    if (accept) begin
      ph_nxt  = PH_ALE;
      cnt_nxt = '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          ph_nxt  = PH_IDLE;
          cnt_nxt = '0;
        end
        PH_ALE: begin
          if (cnt_q == ALE_LAST) begin
            ph_nxt  = PH_HOLD;
            cnt_nxt = '0;
          end else begin
            cnt_nxt = cnt_q + 1'b1;
          end
        end
        PH_HOLD: begin
          ph_nxt  = PH_STRB;
          cnt_nxt = '0;
        end
        PH_STRB: begin
          if (cnt_q == PSEN_LAST) begin
            ph_nxt  = PH_IDLE;
            cnt_nxt = '0;
          end else begin
            cnt_nxt = cnt_q + 1'b1;
          end
        end
        default: begin
          ph_nxt  = PH_IDLE;
          cnt_nxt = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_nxt;
      cnt_q <= cnt_nxt;
    end
  end

  AST_ACCEPT_NOT_MIDFETCH: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_ALE || ph_q == PH_HOLD) |-> !accept); // R7

endmodule

// File: rtl/fetch_bus_drive.sv
module fetch_bus_drive
  import mux_fetch_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LO_W   = 8,
  parameter int CNT_W  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 accept,
  input  logic [ADDR_W-1:0]    addr,
  input  fetch_phase_t         ph_nxt,
  input  logic [CNT_W-1:0]     cnt_nxt,
  output logic                 ale,
  output logic                 psen_n,
  output logic                 p0_oe,
  output logic [LO_W-1:0]      p0_out,
  output logic [ADDR_W-LO_W-1:0] p2_out
);

  logic oe_d;

  always_comb begin
    oe_d = ((ph_nxt == PH_ALE) && (cnt_nxt != '0)) || (ph_nxt == PH_HOLD);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ale    <= 1'b0;
      psen_n <= 1'b1;
      p0_oe  <= 1'b0;
    end else begin
      ale    <= (ph_nxt == PH_ALE);
      psen_n <= (ph_nxt != PH_STRB);
      p0_oe  <= oe_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      p0_out <= '0;
      p2_out <= '0;
    end else if (accept) begin
      p0_out <= addr[LO_W-1:0];
      p2_out <= addr[ADDR_W-1:LO_W];
    end
  end

  AST_ALE_MIN_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(ale) |=> ale); // R1

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    $fell(ale) |-> p0_oe); // R2

  AST_STROBE_GAP: assert property (@(posedge clk) disable iff (rst)
    $fell(psen_n) |-> (!ale && !$past(ale) && $past(ale, 2))); // R3

  AST_PORT_FREE_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
    !psen_n |-> !p0_oe); // R4

  AST_HI_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    !psen_n |-> $stable(p2_out)); // R5

endmodule

// File: rtl/fetch_capture.sv
module fetch_capture #(
  parameter int LO_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            strb_end,
  input  logic [LO_W-1:0] p0_in,
  output logic [LO_W-1:0] instr_out,
  output logic            fetch_done
);

  always_ff @(posedge clk) begin
    if (rst) begin
      instr_out  <= '0;
      fetch_done <= 1'b0;
    end else begin
      fetch_done <= strb_end;
      if (strb_end) begin
        instr_out <= p0_in;
      end
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    fetch_done |=> !fetch_done); // R6

  AST_INSTR_HELD: assert property (@(posedge clk) disable iff (rst)
    !fetch_done |-> $stable(instr_out)); // R6

endmodule

// File: rtl/mux_fetch_seq.sv
module mux_fetch_seq
  import mux_fetch_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int LO_W     = 8,
  parameter int ALE_CYC  = 2,
  parameter int PSEN_CYC = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   fetch_req,
  input  logic [ADDR_W-1:0]      fetch_addr,
  input  logic [LO_W-1:0]        p0_in,
  output logic [LO_W-1:0]        p0_out,
  output logic                   p0_oe,
  output logic [ADDR_W-LO_W-1:0] p2_out,
  output logic                   ale,
  output logic                   psen_n,
  output logic [LO_W-1:0]        instr_out,
  output logic                   fetch_done
);

  localparam int MAX_CYC = (ALE_CYC > PSEN_CYC) ? ALE_CYC : PSEN_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic             accept;
  logic             strb_end;
  fetch_phase_t     ph_nxt;
  logic [CNT_W-1:0] cnt_nxt;

  fetch_seq_ctrl #(
    .ALE_CYC (ALE_CYC),
    .PSEN_CYC(PSEN_CYC),
    .CNT_W   (CNT_W)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .req     (fetch_req),
    .accept  (accept),
    .strb_end(strb_end),
    .ph_nxt  (ph_nxt),
    .cnt_nxt (cnt_nxt)
  );

  fetch_bus_drive #(
    .ADDR_W(ADDR_W),
    .LO_W  (LO_W),
    .CNT_W (CNT_W)
  ) u_drive (
    .clk    (clk),
    .rst    (rst),
    .accept (accept),
    .addr   (fetch_addr),
    .ph_nxt (ph_nxt),
    .cnt_nxt(cnt_nxt),
    .ale    (ale),
    .psen_n (psen_n),
    .p0_oe  (p0_oe),
    .p0_out (p0_out),
    .p2_out (p2_out)
  );

  fetch_capture #(
    .LO_W(LO_W)
  ) u_cap (
    .clk       (clk),
    .rst       (rst),
    .strb_end  (strb_end),
    .p0_in     (p0_in),
    .instr_out (instr_out),
    .fetch_done(fetch_done)
  );

  AST_DONE_AT_STROBE_RISE: assert property (@(posedge clk) disable iff (rst)
    fetch_done |-> $rose(psen_n)); // R6

  AST_STROBE_RISE_GIVES_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(psen_n) |-> fetch_done); // R6

endmodule

// File: tb/mux_fetch_seq_tb.sv
`timescale 1ns/1ps
module mux_fetch_seq_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_req = 1'b0;
  logic [11:0] fetch_addr = '0;
  logic [7:0]  p0_in = '0;
  logic [7:0]  p0_out;
  logic        p0_oe;
  logic [3:0]  p2_out;
  logic        ale;
  logic        psen_n;
  logic [7:0]  instr_out;
  logic        fetch_done;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;

  always #2.5 clk = ~clk;

  mux_fetch_seq u_dut (
    .clk       (clk),
    .rst       (rst),
    .fetch_req (fetch_req),
    .fetch_addr(fetch_addr),
    .p0_in     (p0_in),
    .p0_out    (p0_out),
    .p0_oe     (p0_oe),
    .p2_out    (p2_out),
    .ale       (ale),
    .psen_n    (psen_n),
    .instr_out (instr_out),
    .fetch_done(fetch_done)
  );

  // Behavioural reference: m_t is the period index within a fetch, -1 when idle.
  int          m_t     = -1;
  logic [11:0] m_addr  = '0;
  logic [3:0]  m_hi    = '0;
  logic [7:0]  m_instr = '0;
  logic        m_done  = 1'b0;
  logic        m_rst   = 1'b1;

  always @(posedge clk) begin
    m_rst = rst;
    if (rst) begin
      m_t = -1; m_addr = '0; m_hi = '0; m_instr = '0; m_done = 1'b0;
    end else begin
      m_done = (m_t == 5);
      if (m_t == 5) m_instr = p0_in;
      if ((m_t == -1 || m_t == 5) && fetch_req) begin
        m_t    = 0;
        m_addr = fetch_addr;
        m_hi   = fetch_addr[11:8];
      end else if (m_t == 5) begin
        m_t = -1;
      end else if (m_t >= 0) begin
        m_t = m_t + 1;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic e_ale, e_oe, e_psen_n;
    cyc++;
    e_ale    = (m_t == 0 || m_t == 1);
    e_oe     = (m_t == 1 || m_t == 2);
    e_psen_n = !(m_t >= 3 && m_t <= 5);
    if (m_rst) begin
      chk("R8 ale", ale, 0);
      chk("R8 psen_n", psen_n, 1);
      chk("R8 p0_oe", p0_oe, 0);
      chk("R8 fetch_done", fetch_done, 0);
      chk("R8 instr_out", instr_out, 0);
      chk("R8 p2_out", p2_out, 0);
    end else begin
      chk("R1 R7 ale", ale, e_ale);
      chk("R2 p0_oe", p0_oe, e_oe);
      chk("R3 psen_n", psen_n, e_psen_n);
      if (psen_n === 1'b0) chk("R4 p0_oe during strobe", p0_oe, 0);
      chk("R5 p2_out", p2_out, m_hi);
      if (e_oe) chk("R9 p0_out", p0_out, m_addr[7:0]);
      chk("R6 R7 fetch_done", fetch_done, m_done);
      chk("R6 instr_out", instr_out, m_instr);
    end
    // Memory side: a new byte every period, so a misplaced capture is visible.
    p0_in = 8'((cyc * 29 + 7) & 255);
  end

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic one_fetch(input logic [11:0] a);
    @(negedge clk);
    fetch_req  = 1'b1;
    fetch_addr = a;
    @(negedge clk);
    fetch_req  = 1'b0;
    fetch_addr = ~a;
  endtask

  initial begin
    wait_n(3);
    rst = 1'b0;
    wait_n(2);
    // R1 R2 R3 R6: isolated fetches with extreme addresses
    one_fetch(12'h000); wait_n(8);
    one_fetch(12'hFFF); wait_n(10);
    one_fetch(12'hA5C); wait_n(3);
    // R7: held request with an address changing every period
    @(negedge clk);
    fetch_req = 1'b1;
    for (int i = 0; i < 16; i++) begin
      fetch_addr = 12'h5A3 + 12'(i * 17);
      @(negedge clk);
    end
    fetch_req = 1'b0;
    wait_n(8);
    // R7: a short request in the middle of a fetch is ignored
    one_fetch(12'h3C7);
    @(negedge clk);
    fetch_req = 1'b1; fetch_addr = 12'h777;
    @(negedge clk);
    fetch_req = 1'b0;
    wait_n(10);
    // R8: reset in the middle of a fetch
    one_fetch(12'h2B4);
    wait_n(3);
    rst = 1'b1;
    wait_n(2);
    rst = 1'b0;
    wait_n(3);
    one_fetch(12'hABC); wait_n(9);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule